// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block holds the floating-point status register of a processor FPU and folds the outcome of every completed FP operation into it. The arithmetic, conversion and compare datapaths report five raw IEEE exception flags. For compares they also report a 2-bit relation code. The block marks the flags as current exceptions and tests them against the trap-enable mask. It then either requests a floating-point trap or adds the current exceptions to the accrued set. A compare writes its relation into one of several condition-code fields, chosen by an index.

Software loads the whole register through a single-cycle write port. The rounding-direction field is decoded continuously into a one-hot mode vector that goes straight to the datapath. The register is 64 bits wide because the extra condition-code fields sit above bit 31.

Top module: `fsr_update_unit`

## Requirements
- R1: While rst_ni is low and after its release, fsr_o is all zero and trap_o is low.
- R2: A cycle with wr_en_i high loads wr_data_i into the whole register on the next edge. This holds even when upd_i is high in the same cycle, and trap_o then stays low.
- R3: Each flag in flags_i sets one bit of the current-exception field at bits 4:0: bit 4 invalid, bit 3 overflow, bit 2 underflow, bit 1 divide-by-zero, bit 0 inexact. A flag ORs into the bits already there and never clears one.
- R4: A trap is taken when a current-exception bit i, after the update, meets a set enable bit 23+i in the mask at bits 27:23. The trap-type field at bits 16:14 then becomes 3'b001, and trap_o is high for exactly the one cycle after the update edge.
- R5: On a trap, the accrued-exception field at bits 9:5 is left unchanged and no condition-code field is written.
- R6: When no trap is taken and at least one flag is set, the updated current-exception bits are ORed into the accrued-exception field at bits 9:5.
- R7: A compare update (cmp_i high) writes cmp_rel_i into the condition-code field chosen by cmp_sel_i: index 0 at bits 11:10, index 1 at 33:32, index 2 at 35:34, index 3 at 37:36. The relation codes are equal 00, less 01, greater 10, unordered 11. The other fields keep their values.
- R8: A signaling compare (cmp_sig_i high) with an unordered result raises the invalid flag. A quiet compare does not, so its invalid flag comes only from flags_i.
- R9: An update whose effective flags are all zero leaves the register unchanged. The only exception is the condition-code write of a compare.
- R10: rnd_o is one-hot and decodes bits 31:30: 00 gives round-to-nearest-even (bit 0), 01 gives toward zero (bit 1), 10 gives toward plus infinity (bit 2), 11 gives toward minus infinity (bit 3).
- R11: A cycle with neither wr_en_i nor upd_i leaves fsr_o unchanged and trap_o low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 64 | Value loaded on a write |
| upd_i | input | 1 | An FP operation completes this cycle |
| flags_i | input | 5 | Raw IEEE flags {invalid, overflow, underflow, div-by-zero, inexact} |
| cmp_i | input | 1 | The completing operation is a compare |
| cmp_sig_i | input | 1 | Compare is the signaling form |
| cmp_rel_i | input | 2 | Compare relation code |
| cmp_sel_i | input | 2 | Condition-code field index |
| fsr_o | output | 64 | Status register contents |
| trap_o | output | 1 | One-cycle floating-point trap request |
| rnd_o | output | 4 | One-hot rounding mode for the datapath |

## Verification
The bench builds the block with its default values: a 64-bit register and four condition-code fields. This brings all four field offsets within reach, including the three fields above bit 31. The directed scenarios cover the repeat trap caused by sticky current-exception bits, a masked flag beside an enabled one, and a signaling against a quiet unordered compare. They also cover a write colliding with a trapping update and every rounding-field code.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
  localparam int NFLAG    = 5;
  localparam int CEXC_LSB = 0;
  localparam int AEXC_LSB = 5;
  localparam int CC_BASE  = 10;
  localparam int FTT_LSB  = 14;
  localparam int TEM_LSB  = 23;
  localparam int RD_LSB   = 30;
  localparam int INV_BIT  = 4;
  localparam logic [2:0] FTT_IEEE = 3'b001;

  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  typedef enum logic [1:0] {
    RD_NEAR = 2'b00,
    RD_ZERO = 2'b01,
    RD_POS  = 2'b10,
    RD_NEG  = 2'b11
  } rd_e;

  // field 0 at the base, fields k>0 at base + 20 + 2k
  function automatic int cc_lsb(input int idx);
    return (idx == 0) ? CC_BASE : CC_BASE + 20 + 2 * idx;
  endfunction
endpackage

// File: rtl/fsr_exc_unit.sv
module fsr_exc_unit
  import fsr_pkg::*;
(
  input  logic [NFLAG-1:0] flags_i,
  input  logic             cmp_i,
  input  logic             cmp_sig_i,
  input  logic [1:0]       cmp_rel_i,
  input  logic [NFLAG-1:0] cexc_i,
  input  logic [NFLAG-1:0] tem_i,
  output logic             any_o,
  output logic [NFLAG-1:0] cexc_o,
  output logic             trap_o
);
  logic [NFLAG-1:0] eff;

  always_comb begin
    eff = flags_i;
    if (cmp_i && cmp_sig_i && (cmp_rel_i == REL_UN)) eff[INV_BIT] = 1'b1;
    any_o  = |eff;
    cexc_o = cexc_i | eff;
    trap_o = any_o && |(cexc_o & tem_i);
  end
endmodule

// File: rtl/fsr_cc_unit.sv
module fsr_cc_unit
  import fsr_pkg::*;
#(
  parameter int W      = 64,
  parameter int NUM_CC = 4,
  localparam int SEL_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
) (
  input  logic [W-1:0]     fsr_i,
  input  logic             en_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [1:0]       rel_i,
  output logic [W-1:0]     fsr_o
);
  logic [NUM_CC-1:0] hit;

  for (genvar g = 0; g < NUM_CC; g++) begin : g_cc
    assign hit[g] = en_i && (sel_i == SEL_W'(g));
  end

  always_comb begin
    fsr_o = fsr_i;
    for (int g = 0; g < NUM_CC; g++) begin
      if (hit[g]) fsr_o[cc_lsb(g) +: 2] = rel_i;
    end
  end
endmodule

// File: rtl/fsr_rnd_decode.sv
module fsr_rnd_decode
  import fsr_pkg::*;
(
  input  logic [1:0] rd_i,
  output logic [3:0] rnd_o
);
  always_comb begin
    unique case (rd_e'(rd_i))
      RD_NEAR: rnd_o = 4'b0001;
      RD_ZERO: rnd_o = 4'b0010;
      RD_POS:  rnd_o = 4'b0100;
      RD_NEG:  rnd_o = 4'b1000;
      default: rnd_o = 4'b0010;
    endcase
  end
endmodule

// File: rtl/fsr_update_unit.sv
module fsr_update_unit
  import fsr_pkg::*;
#(
  parameter int W      = 64,
  parameter int NUM_CC = 4,
  localparam int SEL_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [W-1:0]     wr_data_i,
  input  logic             upd_i,
  input  logic [NFLAG-1:0] flags_i,
  input  logic             cmp_i,
  input  logic             cmp_sig_i,
  input  logic [1:0]       cmp_rel_i,
  input  logic [SEL_W-1:0] cmp_sel_i,
  output logic [W-1:0]     fsr_o,
  output logic             trap_o,
  output logic [3:0]       rnd_o
);
  logic [W-1:0]     fsr_q, pre_cc, post_cc;
  logic [NFLAG-1:0] cexc_new;
  logic             any, trap_hit;

  fsr_exc_unit u_exc (
    .flags_i   (flags_i),
    .cmp_i     (cmp_i),
    .cmp_sig_i (cmp_sig_i),
    .cmp_rel_i (cmp_rel_i),
    .cexc_i    (fsr_q[CEXC_LSB +: NFLAG]),
    .tem_i     (fsr_q[TEM_LSB +: NFLAG]),
    .any_o     (any),
    .cexc_o    (cexc_new),
    .trap_o    (trap_hit)
  );

  always_comb begin
    pre_cc = fsr_q;
    if (any) begin
      pre_cc[CEXC_LSB +: NFLAG] = cexc_new;
      if (trap_hit) pre_cc[FTT_LSB +: 3] = FTT_IEEE;
      else          pre_cc[AEXC_LSB +: NFLAG] = fsr_q[AEXC_LSB +: NFLAG] | cexc_new;
    end
  end

  fsr_cc_unit #(.W(W), .NUM_CC(NUM_CC)) u_cc (
    .fsr_i (pre_cc),
    .en_i  (cmp_i && !trap_hit),
    .sel_i (cmp_sel_i),
    .rel_i (cmp_rel_i),
    .fsr_o (post_cc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsr_q  <= '0;
      trap_o <= 1'b0;
    end else begin
      trap_o <= 1'b0;
      if (wr_en_i) begin
        fsr_q <= wr_data_i;
      end else if (upd_i) begin
        fsr_q  <= post_cc;
        trap_o <= trap_hit;
      end
    end
  end

  fsr_rnd_decode u_rnd (
    .rd_i  (fsr_q[RD_LSB +: 2]),
    .rnd_o (rnd_o)
  );

  assign fsr_o = fsr_q;
endmodule

// File: rtl/fsr_update_chk.sv
module fsr_update_chk
  import fsr_pkg::*;
#(
  parameter int W      = 64,
  parameter int NUM_CC = 4,
  localparam int SEL_W = (NUM_CC > 1) ? $clog2(NUM_CC) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [W-1:0]     wr_data_i,
  input logic             upd_i,
  input logic [NFLAG-1:0] flags_i,
  input logic             cmp_i,
  input logic             cmp_sig_i,
  input logic [1:0]       cmp_rel_i,
  input logic [SEL_W-1:0] cmp_sel_i,
  input logic [W-1:0]     fsr_o,
  input logic             trap_o,
  input logic [3:0]       rnd_o
);
  p_reset_clear_r1: assert property (@(posedge clk_i) !rst_ni |=> (rst_ni || (fsr_o == '0 && !trap_o)));

  p_write_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (fsr_o == $past(wr_data_i)) && !trap_o);

  p_flags_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i) |=> ((fsr_o[CEXC_LSB +: NFLAG] & $past(flags_i)) == $past(flags_i)));

  p_trap_type_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> fsr_o[FTT_LSB +: 3] == FTT_IEEE);

  p_trap_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |=> !trap_o || $past(upd_i));

  p_trap_no_accum_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> $stable(fsr_o[AEXC_LSB +: NFLAG]));

  p_quiet_upd_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !wr_en_i && !cmp_i && flags_i == '0) |=> $stable(fsr_o) && !trap_o);

  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!upd_i && !wr_en_i) |=> $stable(fsr_o) && !trap_o);

  always_comb begin
    if (rst_ni) p_rnd_onehot_r10: assert ($countones(rnd_o) == 1);
  end
endmodule

bind fsr_update_unit fsr_update_chk #(.W(W), .NUM_CC(NUM_CC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
  .upd_i(upd_i), .flags_i(flags_i), .cmp_i(cmp_i), .cmp_sig_i(cmp_sig_i),
  .cmp_rel_i(cmp_rel_i), .cmp_sel_i(cmp_sel_i), .fsr_o(fsr_o),
  .trap_o(trap_o), .rnd_o(rnd_o)
);

// File: tb/tb_fsr_update_unit.sv
module tb_fsr_update_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        wr_en = 1'b0, upd = 1'b0, cmp = 1'b0, sig = 1'b0;
  logic [63:0] wr_data = '0;
  logic [4:0]  flags = '0;
  logic [1:0]  rel = '0, sel = '0;
  logic [63:0] fsr;
  logic        trap;
  logic [3:0]  rnd;
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fsr_update_unit dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .upd_i(upd), .flags_i(flags), .cmp_i(cmp), .cmp_sig_i(sig),
    .cmp_rel_i(rel), .cmp_sel_i(sel), .fsr_o(fsr), .trap_o(trap), .rnd_o(rnd)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [63:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic op(input logic [4:0] f, input logic c, input logic s,
                    input logic [1:0] r, input logic [1:0] k);
    @(negedge clk); upd = 1'b1; flags = f; cmp = c; sig = s; rel = r; sel = k;
    @(negedge clk); upd = 1'b0; flags = '0; cmp = 1'b0; sig = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 fsr", fsr, 64'h0);
    chk("R1 trap", {63'h0, trap}, 64'h0);
    chk("R10 rnd nearest", {60'h0, rnd}, 64'h1);
  endtask

  task automatic t_rounding;
    for (int m = 0; m < 4; m++) begin
      wr(64'(m) << 30);
      chk("R2 write", fsr, 64'(m) << 30);
      chk("R10 rnd", {60'h0, rnd}, 64'(1 << m));
    end
  endtask

  task automatic t_accum;
    wr(64'h0);
    op(5'b10000, 0, 0, 0, 0);
    chk("R3 R6 invalid", fsr, 64'h210);
    op(5'b00001, 0, 0, 0, 0);
    chk("R3 R6 inexact sticky", fsr, 64'h231);
    op(5'b00000, 0, 0, 0, 0);
    chk("R9 zero flags", fsr, 64'h231);
  endtask

  task automatic t_trap;
    wr(64'h1 << 26);
    op(5'b01000, 1, 0, 2'b01, 0);
    chk("R4 R5 trap fsr", fsr, 64'h0400_4008);
    chk("R4 trap high", {63'h0, trap}, 64'h1);
    @(negedge clk);
    chk("R4 trap pulse", {63'h0, trap}, 64'h0);
    op(5'b00001, 0, 0, 0, 0);
    chk("R5 repeat trap", fsr, 64'h0400_4009);
    chk("R4 repeat trap", {63'h0, trap}, 64'h1);
    wr(64'h1 << 26);
    op(5'b00001, 0, 0, 0, 0);
    chk("R4 R6 masked", fsr, 64'h0400_0021);
    chk("R4 masked no trap", {63'h0, trap}, 64'h0);
  endtask

  task automatic t_cc;
    wr(64'h0);
    op(5'b0, 1, 0, 2'b01, 2'd0);
    chk("R7 sel0 less", fsr, 64'h400);
    op(5'b0, 1, 0, 2'b10, 2'd1);
    chk("R7 sel1 greater", fsr, 64'h2_0000_0400);
    op(5'b0, 1, 0, 2'b11, 2'd3);
    chk("R7 R9 sel3 quiet unordered", fsr, 64'h32_0000_0400);
    op(5'b0, 1, 0, 2'b00, 2'd0);
    chk("R7 sel0 equal", fsr, 64'h32_0000_0000);
  endtask

  task automatic t_signal;
    wr(64'h0);
    op(5'b0, 1, 1, 2'b11, 2'd2);
    chk("R8 signaling unordered", fsr, 64'hC_0000_0210);
    wr(64'h0);
    op(5'b0, 1, 0, 2'b11, 2'd2);
    chk("R8 quiet unordered", fsr, 64'hC_0000_0000);
    op(5'b0, 1, 1, 2'b01, 2'd2);
    chk("R8 signaling ordered", fsr, 64'h4_0000_0000);
  endtask

  task automatic t_prio;
    wr(64'h0F80_0000);
    @(negedge clk);
    wr_en = 1'b1; wr_data = 64'h1234; upd = 1'b1; flags = 5'b11111;
    @(negedge clk);
    wr_en = 1'b0; upd = 1'b0; flags = '0;
    chk("R2 priority", fsr, 64'h1234);
    chk("R2 no trap", {63'h0, trap}, 64'h0);
  endtask

  task automatic t_idle;
    wr(64'h5A5A);
    repeat (3) @(negedge clk);
    chk("R11 idle", fsr, 64'h5A5A);
    chk("R11 no trap", {63'h0, trap}, 64'h0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_rounding();
    t_accum();
    t_trap();
    t_cc();
    t_signal();
    t_prio();
    t_idle();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule